// File: doc/BRIEF.md
# Downstream Port Power Supervisor

This block switches power for the downstream ports of a hub and protects them against over-current. Hub logic raises a per-port power request. The block drives an active-low enable to each external power switch. It watches an active-low over-current line returned by each switch. The fault lines are synchronized and then deglitched over a fixed window. The window rejects the inrush surge that follows power-on. A fault line is only counted while its own port is powered.

An accepted fault removes power within a bounded response time. It also sets a sticky change flag for that port and lights the port's amber indicator. The port stays off until the hub logic has cleared the flag and withdrawn its request. A fresh request then powers the port again. A strap selects individual or ganged control. In ganged mode any request powers every port, and a fault on any port removes power from all of them.

Top module: `port_power_supervisor`

## Requirements
- R1: After reset, every `pwr_en_n` bit is 1, and `oc_chg`, `led_amber` and `led_green` are all 0. In individual mode, raising `pwr_req[i]` on a port that is off drives `pwr_en_n[i]` low at the next clock edge.
- R2: Hold `oc_n[i]` low on a powered port, starting from clock edge E. Then `pwr_en_n[i]` is still low after edge E+FILT_CYCLES, and it is high after edge E+FILT_CYCLES+1. The default of 15000 cycles at 30 MHz gives about 500 µs.
- R3: An `oc_n[i]` input has no effect while port i is unpowered. The flag stays 0 and no power state changes, however long the input is held low.
- R4: A low pulse on `oc_n[i]` that lasts at most FILT_CYCLES-1 cycles is not accepted. The filter restarts from zero whenever the synchronized input returns high.
- R5: When `gang_mode` is 1, any set bit of `pwr_req` powers all ports, and an accepted fault on any port removes power from all ports at the same edge. When `gang_mode` is 0, a fault removes power only from its own port.
- R6: `oc_chg[i]` is set at the edge after a fault on port i is accepted. It is set only for the port whose fault was accepted, and it stays set until a cycle with `oc_ack[i]` = 1. That cycle clears it at the next edge.
- R7: A port that has lost power to a fault stays unpowered while its request is held. It leaves the fault state only at an edge where its flag is already clear and its request is low; in ganged mode all flags must be clear. A later request then powers it.
- R8: For each port, `led_green[i]` = 1 exactly when the port is powered, and `led_amber[i]` = 1 exactly when the port is in the fault state. Both are 0 when the port is simply off.
- R9: Dropping `pwr_req[i]` on a powered port with no fault drives `pwr_en_n[i]` high at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock (30 MHz in the target system) |
| rst_n | input | 1 | Active-low synchronous reset |
| oc_n | input | NUM_PORTS | Active-low over-current status from each port switch, asynchronous |
| gang_mode | input | 1 | 1 = all ports switched together, 0 = individual control |
| pwr_req | input | NUM_PORTS | Per-port power-on request from hub logic, level |
| oc_ack | input | NUM_PORTS | Write-one-to-clear pulse for the change flags |
| pwr_en_n | output | NUM_PORTS | Active-low power switch enable per port |
| oc_chg | output | NUM_PORTS | Sticky over-current change flag per port |
| led_amber | output | NUM_PORTS | Port fault indicator |
| led_green | output | NUM_PORTS | Port powered indicator |

## Verification
The assertions check several properties on every cycle. An accepted fault always removes power and sets the flag at the following edge. In ganged mode any accepted fault removes power from every port. An acknowledge with no new fault clears the flag. The filter never accepts a fault whose input was not also low in the cycle before, and its counter never passes its limit. A port held in fault with its request raised cannot leave that state.

Some behaviour can only be shown by the bench's scenarios. These are the exact release latency, and the rejection of a pulse one cycle short of the window. They also include the indifference of an unpowered port to its fault line, and the full recovery sequence in both modes.

// File: rtl/pps_pkg.sv
package pps_pkg;

  typedef enum logic [1:0] {
    PS_OFF   = 2'd0,
    PS_ON    = 2'd1,
    PS_FAULT = 2'd2
  } port_state_e;

  // Width of a counter that must reach limit-1.
  function automatic int unsigned cnt_width(int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit);
  endfunction

  // Port power state transition.
  function automatic port_state_e port_next(port_state_e cur, logic req,
                                            logic clear_ok, logic trip);
    case (cur)
      PS_ON:    return trip ? PS_FAULT : (req ? PS_ON : PS_OFF);
      PS_OFF:   return req ? PS_ON : PS_OFF;
      PS_FAULT: return (clear_ok && !req) ? PS_OFF : PS_FAULT;
      default:  return PS_OFF;
    endcase
  endfunction

endpackage

// File: rtl/pps_sync.sv
module pps_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q, sync_q;

  // Active-low inputs: reset to the inactive (high) level.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '1;
      sync_q <= '1;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/pps_oc_filter.sv
module pps_oc_filter #(
  parameter int unsigned LIMIT = 15000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic oc_low,   // synchronized, active high
  input  logic armed,    // port currently powered
  output logic hit       // fault accepted this cycle
);
  localparam int unsigned CW = pps_pkg::cnt_width(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;
  logic          qual;

  assign qual = oc_low && armed;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (!qual)      cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign hit = qual && (cnt == LAST);

  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);  // R4

  generate
    if (LIMIT > 1) begin : g_hold
      AST_HIT_NEEDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> $past(oc_low));  // R4
    end
  endgenerate
endmodule

// File: rtl/pps_port_ctrl.sv
module pps_port_ctrl
  import pps_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        clear_ok,
  input  logic        trip,
  output port_state_e state
);
  always_ff @(posedge clk) begin
    if (!rst_n) state <= PS_OFF;
    else        state <= port_next(state, req, clear_ok, trip);
  end

  AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_FAULT && req) |=> (state == PS_FAULT));  // R7
endmodule

// File: rtl/port_power_supervisor.sv
module port_power_supervisor
  import pps_pkg::*;
#(
  parameter int          NUM_PORTS   = 4,
  parameter int unsigned FILT_CYCLES = 15000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] oc_n,
  input  logic                 gang_mode,
  input  logic [NUM_PORTS-1:0] pwr_req,
  input  logic [NUM_PORTS-1:0] oc_ack,
  output logic [NUM_PORTS-1:0] pwr_en_n,
  output logic [NUM_PORTS-1:0] oc_chg,
  output logic [NUM_PORTS-1:0] led_amber,
  output logic [NUM_PORTS-1:0] led_green
);
  localparam int N = NUM_PORTS;

  logic [N-1:0] oc_n_s, oc_low_s;
  logic [N-1:0] fault_hit, trip, eff_req, clear_ok;
  logic [N-1:0] port_on, port_fault;
  logic [N-1:0] chg_q;
  logic         any_hit;

  pps_sync #(.W(N)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (oc_n),
    .q     (oc_n_s)
  );

  assign oc_low_s = ~oc_n_s;
  assign any_hit  = |fault_hit;
  assign eff_req  = gang_mode ? {N{|pwr_req}} : pwr_req;
  assign clear_ok = gang_mode ? {N{~|chg_q}} : ~chg_q;
  assign trip     = gang_mode ? {N{any_hit}} : fault_hit;

  generate
    for (genvar g = 0; g < N; g++) begin : g_port
      port_state_e st;

      pps_oc_filter #(.LIMIT(FILT_CYCLES)) u_filt (
        .clk    (clk),
        .rst_n  (rst_n),
        .oc_low (oc_low_s[g]),
        .armed  (port_on[g]),
        .hit    (fault_hit[g])
      );

      pps_port_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (eff_req[g]),
        .clear_ok (clear_ok[g]),
        .trip     (trip[g]),
        .state    (st)
      );

      assign port_on[g]    = (st == PS_ON);
      assign port_fault[g] = (st == PS_FAULT);

      AST_HIT_CUTS_POWER: assert property (@(posedge clk) disable iff (!rst_n)
        fault_hit[g] |=> pwr_en_n[g]);  // R2
      AST_HIT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        fault_hit[g] |=> oc_chg[g]);  // R6
      AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (oc_ack[g] && !fault_hit[g]) |=> !oc_chg[g]);  // R6
    end
  endgenerate

  // Sticky flags: a new fault wins over a simultaneous acknowledge.
  always_ff @(posedge clk) begin
    if (!rst_n) chg_q <= '0;
    else        chg_q <= (chg_q & ~oc_ack) | fault_hit;
  end

  assign oc_chg    = chg_q;
  assign pwr_en_n  = ~port_on;
  assign led_green = port_on;
  assign led_amber = port_fault;

  AST_GANG_CUT_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (gang_mode && any_hit) |=> (&pwr_en_n));  // R5
endmodule

// File: tb/port_power_supervisor_test.sv
module port_power_supervisor_test;
  localparam int N = 4;
  localparam int F = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] oc_n = '1;
  logic         gang_mode = 1'b0;
  logic [N-1:0] pwr_req = '0;
  logic [N-1:0] oc_ack = '0;
  logic [N-1:0] pwr_en_n, oc_chg, led_amber, led_green;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct {
    int           tgt;
    logic [N-1:0] pe, chg, amb, grn;
    string        tag;
  } exp_t;
  exp_t sb[$];

  port_power_supervisor #(.NUM_PORTS(N), .FILT_CYCLES(F)) uut (
    .clk(clk), .rst_n(rst_n), .oc_n(oc_n), .gang_mode(gang_mode),
    .pwr_req(pwr_req), .oc_ack(oc_ack), .pwr_en_n(pwr_en_n),
    .oc_chg(oc_chg), .led_amber(led_amber), .led_green(led_green)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver side: expectation for d edges after the current negedge.
  task automatic expect_at(int d, logic [N-1:0] pe, logic [N-1:0] chg,
                           logic [N-1:0] amb, logic [N-1:0] grn, string tag);
    exp_t e;
    e.tgt = cyc + d; e.pe = pe; e.chg = chg; e.amb = amb; e.grn = grn; e.tag = tag;
    sb.push_back(e);
  endtask

  // Monitor: compare after each edge, away from it.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      while (sb.size() > 0 && sb[0].tgt <= cyc) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (e.tgt != cyc || pwr_en_n !== e.pe || oc_chg !== e.chg ||
            led_amber !== e.amb || led_green !== e.grn) begin
          fails++;
          $display("FAIL %s: got pe=%b chg=%b amb=%b grn=%b, expected pe=%b chg=%b amb=%b grn=%b",
                   e.tag, pwr_en_n, oc_chg, led_amber, led_green, e.pe, e.chg, e.amb, e.grn);
        end
      end
    end
  end

  initial begin
    tick(4);
    rst_n = 1'b1;
    expect_at(1, 4'b1111, 4'b0000, 4'b0000, 4'b0000, "R1 reset state");
    tick(2);

    // Individual mode power-on
    pwr_req = 4'b0011;
    expect_at(1, 4'b1100, 4'b0000, 4'b0000, 4'b0011, "R1 power on");
    tick(3);

    // Glitch one cycle short of the window
    oc_n[0] = 1'b0;
    tick(F - 1);
    oc_n[0] = 1'b1;
    expect_at(F + 4, 4'b1100, 4'b0000, 4'b0000, 4'b0011, "R4 short pulse rejected");
    tick(F + 6);

    // Fault on an unpowered port
    oc_n[3] = 1'b0;
    tick(2 * F);
    expect_at(1, 4'b1100, 4'b0000, 4'b0000, 4'b0011, "R3 unpowered port ignores fault");
    oc_n[3] = 1'b1;
    tick(3);

    // Accepted fault on port 1
    oc_n[1] = 1'b0;
    expect_at(F + 1, 4'b1100, 4'b0000, 4'b0000, 4'b0011, "R2 still powered");
    expect_at(F + 2, 4'b1110, 4'b0010, 4'b0010, 4'b0001, "R2 R5 R8 release own port");
    tick(F + 4);
    oc_n[1] = 1'b1;
    tick(4);
    expect_at(1, 4'b1110, 4'b0010, 4'b0010, 4'b0001, "R7 held off with request");
    tick(1);

    oc_ack = 4'b0010;
    expect_at(1, 4'b1110, 4'b0000, 4'b0010, 4'b0001, "R6 flag cleared, R7 still fault");
    tick(1);
    oc_ack = 4'b0000;
    tick(2);

    pwr_req = 4'b0001;
    expect_at(1, 4'b1110, 4'b0000, 4'b0000, 4'b0001, "R7 fault to off");
    tick(2);
    pwr_req = 4'b0011;
    expect_at(1, 4'b1100, 4'b0000, 4'b0000, 4'b0011, "R7 repower");
    tick(2);
    pwr_req = 4'b0000;
    expect_at(1, 4'b1111, 4'b0000, 4'b0000, 4'b0000, "R9 request drop");
    tick(2);

    // Ganged mode
    gang_mode = 1'b1;
    tick(2);
    pwr_req = 4'b0100;
    expect_at(1, 4'b0000, 4'b0000, 4'b0000, 4'b1111, "R5 ganged power on");
    tick(3);
    oc_n[2] = 1'b0;
    expect_at(F + 1, 4'b0000, 4'b0000, 4'b0000, 4'b1111, "R2 ganged still powered");
    expect_at(F + 2, 4'b1111, 4'b0100, 4'b1111, 4'b0000, "R5 R6 ganged cut all");
    tick(F + 4);
    oc_n[2] = 1'b1;
    tick(3);
    oc_ack = 4'b0100;
    expect_at(1, 4'b1111, 4'b0000, 4'b1111, 4'b0000, "R6 ganged flag cleared");
    tick(1);
    oc_ack = 4'b0000;
    pwr_req = 4'b0000;
    expect_at(1, 4'b1111, 4'b0000, 4'b0000, 4'b0000, "R7 ganged fault to off");
    tick(2);
    pwr_req = 4'b1000;
    expect_at(1, 4'b0000, 4'b0000, 4'b0000, 4'b1111, "R5 ganged repower");
    tick(4);

    if (sb.size() != 0) begin
      fails += sb.size();
      checks += sb.size();
      $display("FAIL pending: %0d expectations unchecked, expected 0", sb.size());
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule